// File: doc/BRIEF.md
# USB Frame Timing Counter

This block keeps frame time for a full-speed USB host controller. Software programs a frame length in bit times, together with a maximum-packet-size field and a toggle flag. A down-counter runs on a bit-time clock enable while the controller is operational. When the counter reaches zero it loads the programmed length again, copies the toggle flag, advances a 16-bit frame number, and raises a start-of-frame event. If bit 15 of the frame number changes on that advance, a frame-number-overflow event is raised as well.

A second programmable value, the periodic-start threshold, is compared against the remaining count. A level output marks the part of each frame in which periodic traffic has priority. Software reaches four 32-bit words through a single-cycle write port and a combinational read port. Two of these words can be written. The remaining-time word and the frame-number word are read-only.

Top module: `usb_frame_timer`

## Requirements
- R1: After reset, the interval word reads 11999 in bits 13:0 with every other bit 0. The remaining word reads 11999. The frame number reads 0. The threshold word reads 10800. All three event and level outputs are low.
- R2: On a clock edge where `bit_tick_i` and `run_i` are both high and the remaining count is not zero, the count drops by exactly one.
- R3: When `run_i` is low or `bit_tick_i` is low, the remaining count, the frame number and the copied toggle do not change, and no event is raised.
- R4: On an advancing edge where the count is zero, the count reloads from interval bits 13:0 and the interval toggle (bit 31) is copied into bit 31 of the remaining word (address 1, count in bits 13:0).
- R5: Each reload increments the frame number (address 2, bits 15:0) by one, wrapping from 65535 to 0.
- R6: `sof_o` is high for exactly the cycle that follows each reload edge. In that cycle the new count and the new frame number are already visible.
- R7: `fno_o` is high in the same cycle as `sof_o` when that reload changed bit 15 of the frame number (frame 32767 to 32768, and 65535 to 0), and is low otherwise.
- R8: `periodic_o` is high exactly while the remaining count is less than or equal to the threshold at address 3, bits 13:0.
- R9: The interval word at address 0 holds the count in bits 13:0, the packet size in bits 30:16 and the toggle in bit 31. Bits 15:14 read 0 and ignore writes. A new interval takes effect only at the next reload and leaves the running count untouched.
- R10: Writes to address 1 and address 2 have no effect on any readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_tick_i | input | 1 | One-cycle enable per bit time |
| run_i | input | 1 | High while the controller is operational |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Word select: 0 interval, 1 remaining, 2 frame number, 3 threshold |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| sof_o | output | 1 | Start-of-frame pulse |
| fno_o | output | 1 | Frame-number-overflow pulse |
| periodic_o | output | 1 | Periodic-priority window |

## Verification
The count, the frame number, the copied toggle and both event pulses are registered. Each one therefore shows the effect of a tick or a write one clock edge after that input is applied. `periodic_o` and `rdata_o` follow combinationally from that registered state. The bench drives inputs after a falling edge and lets one rising edge pass. It samples every output at the next falling edge and compares it against a reference model advanced by exactly one step per edge. As a result, every check lands on the first cycle in which a result is due and never on the cycle before it.

// File: rtl/uft_pkg.sv
package uft_pkg;
  localparam int FI_W = 14;
  localparam int FS_W = 15;
  localparam int FN_W = 16;
  localparam int DW   = 32;

  typedef enum logic [1:0] {
    REG_IVL    = 2'd0,
    REG_REM    = 2'd1,
    REG_FNUM   = 2'd2,
    REG_PSTART = 2'd3
  } uft_reg_e;
endpackage

// File: rtl/uft_regs.sv
module uft_regs
  import uft_pkg::*;
#(
  parameter int          IW     = FI_W,
  parameter int          SW     = FS_W,
  parameter int          NW     = FN_W,
  parameter logic [IW-1:0] FI_RST = IW'(11999),
  parameter logic [IW-1:0] PS_RST = IW'(10800)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [IW-1:0] rem_i,
  input  logic          rem_tgl_i,
  input  logic [NW-1:0] fn_i,
  output logic [IW-1:0] fi_o,
  output logic          fi_tgl_o,
  output logic [IW-1:0] ps_o,
  output logic [DW-1:0] rdata_o
);
  localparam int TGL_B = DW - 1;
  localparam int FS_LO = 16;

  logic [SW-1:0] fs_q;
  logic [IW-1:0] fi_q, ps_q;
  logic          tgl_q;
  logic          unused_wbits;

  assign unused_wbits = ^wdata_i[FS_LO-1:IW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fi_q  <= FI_RST;
      fs_q  <= '0;
      tgl_q <= 1'b0;
      ps_q  <= PS_RST;
    end else if (wr_en_i) begin
      case (uft_reg_e'(addr_i))
        REG_IVL: begin
          fi_q  <= wdata_i[IW-1:0];
          fs_q  <= wdata_i[FS_LO+SW-1:FS_LO];
          tgl_q <= wdata_i[TGL_B];
        end
        REG_PSTART: ps_q <= wdata_i[IW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (uft_reg_e'(addr_i))
      REG_IVL: begin
        rdata_o[IW-1:0]            = fi_q;
        rdata_o[FS_LO+SW-1:FS_LO]  = fs_q;
        rdata_o[TGL_B]             = tgl_q;
      end
      REG_REM: begin
        rdata_o[IW-1:0] = rem_i;
        rdata_o[TGL_B]  = rem_tgl_i;
      end
      REG_FNUM:   rdata_o[NW-1:0] = fn_i;
      REG_PSTART: rdata_o[IW-1:0] = ps_q;
      default: ;
    endcase
  end

  assign fi_o     = fi_q;
  assign fi_tgl_o = tgl_q;
  assign ps_o     = ps_q;
endmodule

// File: rtl/uft_remaining.sv
module uft_remaining #(
  parameter int            IW     = 14,
  parameter logic [IW-1:0] FI_RST = IW'(11999)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic [IW-1:0] fi_i,
  input  logic          fi_tgl_i,
  output logic [IW-1:0] rem_o,
  output logic          rem_tgl_o,
  output logic          wrap_o
);
  logic [IW-1:0] rem_q;
  logic          tgl_q;

  assign wrap_o = adv_i && (rem_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= FI_RST;
      tgl_q <= 1'b0;
    end else if (wrap_o) begin
      rem_q <= fi_i;
      tgl_q <= fi_tgl_i;
    end else if (adv_i) begin
      rem_q <= rem_q - 1'b1;
    end
  end

  assign rem_o     = rem_q;
  assign rem_tgl_o = tgl_q;
endmodule

// File: rtl/uft_frame_num.sv
module uft_frame_num #(
  parameter int NW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  output logic [NW-1:0] fn_o,
  output logic          sof_o,
  output logic          fno_o
);
  localparam int MSB = NW - 1;

  logic [NW-1:0] fn_q;
  logic          sof_q, fno_q;
  logic          msb_flip;

  // next increment carries into the top bit
  assign msb_flip = &fn_q[MSB-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fn_q  <= '0;
      sof_q <= 1'b0;
      fno_q <= 1'b0;
    end else begin
      sof_q <= step_i;
      fno_q <= step_i && msb_flip;
      if (step_i) fn_q <= fn_q + 1'b1;
    end
  end

  assign fn_o  = fn_q;
  assign sof_o = sof_q;
  assign fno_o = fno_q;
endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer
  import uft_pkg::*;
#(
  parameter int            IW     = FI_W,
  parameter int            SW     = FS_W,
  parameter int            NW     = FN_W,
  parameter logic [IW-1:0] FI_RST = IW'(11999),
  parameter logic [IW-1:0] PS_RST = IW'(10800)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bit_tick_i,
  input  logic          run_i,
  input  logic          wr_en_i,
  input  logic [1:0]    addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  output logic          sof_o,
  output logic          fno_o,
  output logic          periodic_o
);
  logic [IW-1:0] rem_w, fi_w, ps_w;
  logic [NW-1:0] fn_w;
  logic          rem_tgl_w, fi_tgl_w, wrap_w, adv_w;

  assign adv_w = bit_tick_i && run_i;

  uft_regs #(.IW(IW), .SW(SW), .NW(NW), .FI_RST(FI_RST), .PS_RST(PS_RST)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rem_i     (rem_w),
    .rem_tgl_i (rem_tgl_w),
    .fn_i      (fn_w),
    .fi_o      (fi_w),
    .fi_tgl_o  (fi_tgl_w),
    .ps_o      (ps_w),
    .rdata_o   (rdata_o)
  );

  uft_remaining #(.IW(IW), .FI_RST(FI_RST)) u_rem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (adv_w),
    .fi_i      (fi_w),
    .fi_tgl_i  (fi_tgl_w),
    .rem_o     (rem_w),
    .rem_tgl_o (rem_tgl_w),
    .wrap_o    (wrap_w)
  );

  uft_frame_num #(.NW(NW)) u_fn (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (wrap_w),
    .fn_o   (fn_w),
    .sof_o  (sof_o),
    .fno_o  (fno_o)
  );

  assign periodic_o = (rem_w <= ps_w);
endmodule

// File: rtl/uft_chk.sv
module uft_chk #(
  parameter int IW = 14,
  parameter int NW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bit_tick_i,
  input logic          run_i,
  input logic          sof_o,
  input logic          fno_o,
  input logic [IW-1:0] rem_i,
  input logic [IW-1:0] fi_i,
  input logic [NW-1:0] fn_i
);
  // R2
  dec_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_tick_i && run_i && rem_i != '0) |=> (rem_i == IW'($past(rem_i) - 1'b1)));

  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bit_tick_i && run_i) |=> ($stable(rem_i) && $stable(fn_i) && !sof_o));

  // R4
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> (rem_i == $past(fi_i)));

  // R5
  fn_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> (fn_i == NW'($past(fn_i) + 1'b1)));

  // R7
  fno_with_sof_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fno_o |-> (sof_o && $past(fn_i[NW-1]) != fn_i[NW-1]));
endmodule

bind usb_frame_timer uft_chk #(.IW(IW), .NW(NW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bit_tick_i (bit_tick_i),
  .run_i      (run_i),
  .sof_o      (sof_o),
  .fno_o      (fno_o),
  .rem_i      (rem_w),
  .fi_i       (fi_w),
  .fn_i       (fn_w)
);

// File: tb/sim_usb_frame_timer.sv
module sim_usb_frame_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, run = 1'b0, we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sof, fno, per;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // reference model state
  logic [13:0] m_fi = 14'd11999, m_ps = 14'd10800, m_rem = 14'd11999;
  logic [14:0] m_fs = '0;
  logic        m_fit = 1'b0, m_frt = 1'b0, m_sof = 1'b0, m_fno = 1'b0;
  logic [15:0] m_fn = '0;

  always #4 clk = ~clk;

  usb_frame_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .bit_tick_i(tick), .run_i(run),
    .wr_en_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .sof_o(sof), .fno_o(fno), .periodic_o(per)
  );

  function automatic logic [31:0] model_read(input logic [1:0] a);
    case (a)
      2'd0:    return {m_fit, m_fs, 2'b00, m_fi};
      2'd1:    return {m_frt, 17'd0, m_rem};
      2'd2:    return {16'd0, m_fn};
      default: return {18'd0, m_ps};
    endcase
  endfunction

  function automatic string read_req(input logic [1:0] a);
    case (a)
      2'd0:    return "R9";
      2'd1:    return "R2 R4";
      2'd2:    return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_edge();
    logic adv, wrap;
    adv  = tick && run;
    wrap = adv && (m_rem == 14'd0);
    m_sof = wrap;
    m_fno = wrap && (m_fn[14:0] == 15'h7fff);
    if (wrap) begin
      m_rem = m_fi;
      m_frt = m_fit;
      m_fn  = m_fn + 16'd1;
    end else if (adv) begin
      m_rem = m_rem - 14'd1;
    end
    if (we && addr == 2'd0) begin
      m_fi  = wdata[13:0];
      m_fs  = wdata[30:16];
      m_fit = wdata[31];
    end else if (we && addr == 2'd3) begin
      m_ps = wdata[13:0];
    end
  endtask

  task automatic compare_all();
    check(read_req(addr), rdata, model_read(addr));
    check("R6", {31'd0, sof}, {31'd0, m_sof});
    check("R7", {31'd0, fno}, {31'd0, m_fno});
    check("R8", {31'd0, per}, {31'd0, (m_rem <= m_ps)});
  endtask

  // inputs driven after a falling edge; results sampled at the next falling edge
  task automatic step(input logic t, input logic r, input logic w,
                      input logic [1:0] a, input logic [31:0] d);
    tick = t; run = r; we = w; addr = a; wdata = d;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] held_rem, held_fn;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    addr = 2'd0; #1 check("R1", rdata, 32'd11999);
    addr = 2'd1; #1 check("R1", rdata, 32'd11999);
    addr = 2'd2; #1 check("R1", rdata, 32'd0);
    addr = 2'd3; #1 check("R1", rdata, 32'd10800);
    check("R1", {29'd0, sof, fno, per}, 32'd0);

    // R10: writes to read-only words
    step(1'b0, 1'b0, 1'b1, 2'd1, 32'hffff_ffff);
    step(1'b0, 1'b0, 1'b1, 2'd2, 32'hffff_ffff);
    addr = 2'd1; #1 check("R10", rdata, 32'd11999);
    addr = 2'd2; #1 check("R10", rdata, 32'd0);

    // R9: reserved bits, packet size, toggle; running count untouched
    step(1'b0, 1'b0, 1'b1, 2'd0, 32'hffff_c005);
    check("R9", rdata, 32'hffff_0005);
    addr = 2'd1; #1 check("R9", rdata, 32'd11999);

    // R3: tick without run, run without tick
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 1'b0, 2'd1, '0);
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1, 1'b0, 2'd1, '0);
    check("R3", rdata, 32'd11999);

    // drain to first reload; R4 toggle copy
    step(1'b0, 1'b0, 1'b1, 2'd3, 32'd3);
    for (int i = 0; i < 12000; i++) step(1'b1, 1'b1, 1'b0, 2'd1, '0);
    check("R4", rdata, 32'h8000_0005);
    check("R6", {31'd0, sof}, 32'd1);

    // constrained random
    for (int i = 0; i < 30000; i++) begin
      logic w;
      logic [1:0] a;
      logic [31:0] d;
      w = ($urandom_range(0, 15) == 0);
      a = 2'($urandom_range(0, 3));
      d = $urandom();
      d[13:0] = 14'($urandom_range(0, 40));
      step($urandom_range(0, 3) != 0, $urandom_range(0, 7) != 0, w, a, d);
    end

    // R3 directed: halted count holds across ticks
    addr = 2'd1; #1 held_rem = rdata;
    addr = 2'd2; #1 held_fn = rdata;
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, 2'd1, '0);
    check("R3", {18'd0, rdata[13:0]}, {18'd0, held_rem[13:0]});
    addr = 2'd2; #1 check("R3", rdata, held_fn);

    // R5 R7: zero interval, one frame per tick, run through a full wrap
    step(1'b0, 1'b0, 1'b1, 2'd0, 32'd0);
    for (int i = 0; i < 65540; i++) step(1'b1, 1'b1, 1'b0, 2'd2, '0);
    addr = 2'd2; #1 check("R5", rdata, {16'd0, m_fn});

    done = 1'b1;
    summary();
    $finish;
  end
endmodule